// File: doc/BRIEF.md
# Configurable Serial Transmitter with Break and Loopback

This block turns one data word at a time into an asynchronous serial frame on a single transmit line. Software-facing configuration arrives as plain inputs: a 2-bit word-length code, a stop-bit select, a 3-bit parity mode, a baud divisor, and control bits for transmit enable, send break, loopback and transmit-interrupt enable. A word is written into a one-entry holding register. When the transmitter is idle and enabled, the word is copied into a shift register and sent. Each bit lasts sixteen ticks of a clock enable that fires every divisor + 1 clock cycles.

A status output reports when both the holding register and the shift register are empty. An interrupt level reports an empty holding register. Send break forces the line low while a frame is timed in the background, so the end of a break can be timed by one written word. Loopback holds the line high and hands each written word straight to a receiver-side port.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd_o` is 1, `empty_o` is 1, `lb_valid_o` is 0, and `irq_o` is 0 while `irq_en_i` is 0.
- R2: A frame is a start bit of 0, then the data bits least significant first, then the optional parity bit, then the stop bits of 1. `wlen_i` codes 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits. Data bits above the selected length are discarded. Frames written one after another are sent in write order.
- R3: `two_stop_i` = 0 gives one stop bit and `two_stop_i` = 1 gives two.
- R4: `par_mode_i` with bit 2 = 0 adds no parity bit. Code 100 adds a bit that makes the number of ones in data plus parity odd. Code 101 makes that number even. Code 110 adds a constant 1 and code 111 a constant 0.
- R5: Every bit of a frame lasts exactly 16 × (`div_i` + 1) clock cycles. The start bit begins on the clock edge after the word moves from the holding register into the shifter.
- R6: A written word stays in the holding register, and the line stays high, while `tx_en_i` is 0. It is sent once `tx_en_i` becomes 1.
- R7: `empty_o` is 1 exactly when neither register holds a word. It falls on the edge that accepts a write. For a frame of N bits written into an idle transmitter, it rises N × 16 × (`div_i` + 1) + 1 cycles after that edge.
- R8: `irq_o` is 1 exactly when `irq_en_i` is 1 and the holding register is empty.
- R9: A write while the holding register is occupied is ignored and the held word is kept.
- R10: While `brk_i` is 1 and loopback is off, `txd_o` is 0. A written word is still timed as a full frame, so `empty_o` returns to 1 after the same number of cycles as in R7.
- R11: While `lpbk_i` is 1, `txd_o` is 1 and no frame is sent. A word in the holding register is presented on `lb_data_o`, masked to the word length, with a one-cycle `lb_valid_o` pulse on the edge after the write. The holding register is then empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Baud divisor; tick every div_i+1 cycles |
| wlen_i | input | 2 | Word length code (5 + code bits) |
| two_stop_i | input | 1 | 0: one stop bit, 1: two stop bits |
| par_mode_i | input | 3 | Parity mode code |
| tx_en_i | input | 1 | Transmit enable |
| brk_i | input | 1 | Send break: force line low |
| lpbk_i | input | 1 | Loopback: line high, words to receiver port |
| irq_en_i | input | 1 | Transmit interrupt enable |
| wr_i | input | 1 | Write strobe for the holding register |
| wdata_i | input | 8 | Word to transmit |
| txd_o | output | 1 | Serial transmit line |
| empty_o | output | 1 | Holding and shift registers both empty |
| irq_o | output | 1 | Transmit interrupt level |
| lb_valid_o | output | 1 | Loopback word valid pulse |
| lb_data_o | output | 8 | Loopback word, masked to word length |

## Verification
Frames are sent with every word-length code, with each parity code and with both stop settings. Data values are chosen so that the parity bit differs between the odd and even codes and masked upper bits would show up if they leaked through. Bit length is measured at two divisor values, which separates a correct divide-by-(div+1) from an off-by-one count, and the empty-flag timing is measured in cycles for frames of different lengths. Gating by transmit enable, a write into a full holding register, back-to-back writes, break timing and loopback hand-off each get their own pattern, so a stuck or swapped override shows up as a wrong line level or a missing or extra frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int MAX_DW  = 8;
  localparam int FRAME_W = MAX_DW + 4;
  localparam int BCNT_W  = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [BCNT_W-1:0]  nbits;
  } frame_t;

  function automatic int unsigned wl_bits(input logic [1:0] code);
    return 5 + int'(code);
  endfunction

  function automatic logic [MAX_DW-1:0] mask_word(input logic [MAX_DW-1:0] d,
                                                  input logic [1:0] code);
    logic [MAX_DW-1:0] m;
    for (int i = 0; i < MAX_DW; i++) m[i] = d[i] & (i < int'(wl_bits(code)));
    return m;
  endfunction

  // Full frame, LSB goes out first; unused upper bits stay 1 (stop level).
  function automatic frame_t build_frame(input logic [MAX_DW-1:0] d,
                                         input logic [1:0] code,
                                         input logic two_stop,
                                         input logic [2:0] pmode);
    frame_t f;
    logic [MAX_DW-1:0] md;
    logic pbit;
    int pos;
    md = mask_word(d, code);
    f.bits = '1;
    f.bits[0] = 1'b0;
    for (int i = 0; i < MAX_DW; i++)
      if (i < int'(wl_bits(code))) f.bits[1+i] = md[i];
    pos = 1 + int'(wl_bits(code));
    case (pmode[1:0])
      2'b00:   pbit = ~^md;
      2'b01:   pbit = ^md;
      2'b10:   pbit = 1'b1;
      default: pbit = 1'b0;
    endcase
    if (pmode[2]) begin
      for (int i = 0; i < FRAME_W; i++)
        if (i == pos) f.bits[i] = pbit;
      pos = pos + 1;
    end
    pos = pos + (two_stop ? 2 : 1);
    f.nbits = BCNT_W'(pos);
    return f;
  endfunction
endpackage

// File: rtl/sertx_tick.sv
module sertx_tick #(
  parameter int DIV_W = 12,
  parameter int OVS   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_end_o
);
  localparam int OS_W = $clog2(OVS);

  logic [DIV_W-1:0] div_cnt;
  logic [OS_W-1:0]  os_cnt;
  logic             tick;

  assign tick      = run_i && (div_cnt >= div_i);
  assign bit_end_o = tick && (os_cnt == OS_W'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt <= '0;
      os_cnt  <= '0;
    end else if (clr_i || !run_i) begin
      div_cnt <= '0;
      os_cnt  <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      os_cnt  <= os_cnt + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assert_clr_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (div_cnt == '0 && os_cnt == '0));
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MAX_DW-1:0] wdata_i,
  input  logic              take_i,
  input  logic              lpbk_i,
  input  logic [1:0]        wlen_i,
  output logic              valid_o,
  output logic [MAX_DW-1:0] data_o,
  output logic              lb_valid_o,
  output logic [MAX_DW-1:0] lb_data_o
);
  logic              valid_q;
  logic [MAX_DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= 1'b0;
      data_q     <= '0;
      lb_valid_o <= 1'b0;
      lb_data_o  <= '0;
    end else begin
      lb_valid_o <= 1'b0;
      if (valid_q && lpbk_i) begin
        valid_q    <= 1'b0;
        lb_valid_o <= 1'b1;
        lb_data_o  <= mask_word(data_q, wlen_i);
      end else if (valid_q && take_i) begin
        valid_q <= 1'b0;
      end else if (!valid_q && wr_i) begin
        valid_q <= 1'b1;
        data_q  <= wdata_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  assert_full_wr_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && wr_i |=> data_q == $past(data_q));
  assert_lb_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_valid_o |-> !valid_q || $past(wr_i));
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  frame_t frame_i,
  input  logic   bit_end_i,
  output logic   busy_o,
  output logic   line_o
);
  logic [FRAME_W-1:0] sreg;
  logic [BCNT_W-1:0]  left;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg <= '1;
      left <= '0;
    end else if (load_i) begin
      sreg <= frame_i.bits;
      left <= frame_i.nbits;
    end else if (bit_end_i && left != '0) begin
      sreg <= {1'b1, sreg[FRAME_W-1:1]};
      left <= left - 1'b1;
    end
  end

  assign busy_o = (left != '0);
  assign line_o = busy_o ? sreg[0] : 1'b1;

  assert_end_on_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(bit_end_i));
  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !line_o);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int OVS   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [1:0]        wlen_i,
  input  logic              two_stop_i,
  input  logic [2:0]        par_mode_i,
  input  logic              tx_en_i,
  input  logic              brk_i,
  input  logic              lpbk_i,
  input  logic              irq_en_i,
  input  logic              wr_i,
  input  logic [MAX_DW-1:0] wdata_i,
  output logic              txd_o,
  output logic              empty_o,
  output logic              irq_o,
  output logic              lb_valid_o,
  output logic [MAX_DW-1:0] lb_data_o
);
  logic              hold_valid;
  logic [MAX_DW-1:0] hold_data;
  logic              busy, line, load, bit_end;
  frame_t            frame;

  assign load  = hold_valid && !busy && tx_en_i && !lpbk_i;
  assign frame = build_frame(hold_data, wlen_i, two_stop_i, par_mode_i);

  sertx_hold u_hold (
    .clk_i, .rst_ni, .wr_i, .wdata_i,
    .take_i     (load),
    .lpbk_i, .wlen_i,
    .valid_o    (hold_valid),
    .data_o     (hold_data),
    .lb_valid_o, .lb_data_o
  );

  sertx_tick #(.DIV_W(DIV_W), .OVS(OVS)) u_tick (
    .clk_i, .rst_ni,
    .clr_i     (load),
    .run_i     (busy),
    .div_i,
    .bit_end_o (bit_end)
  );

  sertx_shift u_shift (
    .clk_i, .rst_ni,
    .load_i    (load),
    .frame_i   (frame),
    .bit_end_i (bit_end),
    .busy_o    (busy),
    .line_o    (line)
  );

  // Loopback wins over break; break wins over data.
  always_comb begin
    if (lpbk_i)     txd_o = 1'b1;
    else if (brk_i) txd_o = 1'b0;
    else            txd_o = line;
  end

  assign empty_o = !hold_valid && !busy;
  assign irq_o   = irq_en_i && !hold_valid;

  assert_empty_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && empty_o |=> !empty_o);
  assert_irq_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_i && empty_o |-> irq_o);
  assert_tx_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(tx_en_i) && !$past(lpbk_i));
  assert_lb_mode_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_valid_o |-> $past(lpbk_i));
  assert_idle_line_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && !brk_i |-> txd_o);
endmodule

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
  localparam int DIV_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0] div = 12'd1;
  logic [1:0] wlen = 2'b11;
  logic two_stop = 1'b0, tx_en = 1'b0, brk = 1'b0, lpbk = 1'b0, irq_en = 1'b0, wr = 1'b0;
  logic [2:0] pmode = 3'b000;
  logic [7:0] wdata = '0;
  logic txd, empty, irq, lb_valid;
  logic [7:0] lb_data;

  int checks = 0, errors = 0, frames_seen = 0;
  int bit_cyc = 32;
  bit mon_on = 1'b1, done = 1'b0;

  logic [11:0] q_bits[$];
  int          q_n[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  sertx_top #(.DIV_W(DIV_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .wlen_i(wlen), .two_stop_i(two_stop),
    .par_mode_i(pmode), .tx_en_i(tx_en), .brk_i(brk), .lpbk_i(lpbk), .irq_en_i(irq_en),
    .wr_i(wr), .wdata_i(wdata), .txd_o(txd), .empty_o(empty), .irq_o(irq),
    .lb_valid_o(lb_valid), .lb_data_o(lb_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected frame from the requirement text: start, data LSB first, parity, stops.
  task automatic expect_frame(input logic [7:0] d, input string tag);
    logic [11:0] b;
    int n, nd, ones;
    nd = 5 + int'(wlen);
    b = '1; b[0] = 1'b0; ones = 0;
    for (int i = 0; i < nd; i++) begin b[1+i] = d[i]; ones += int'(d[i]); end
    n = 1 + nd;
    if (pmode[2]) begin
      case (pmode[1:0])
        2'b00: b[n] = (ones % 2 == 0);
        2'b01: b[n] = (ones % 2 == 1);
        2'b10: b[n] = 1'b1;
        default: b[n] = 1'b0;
      endcase
      n++;
    end
    n += two_stop ? 2 : 1;
    q_bits.push_back(b); q_n.push_back(n); q_tag.push_back(tag);
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (!empty) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input string tag);
    expect_frame(d, tag);
    put(d);
    wait_idle();
  endtask

  // Monitor: sample each bit at its middle, compare against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && rst_n && txd === 1'b0) begin
        logic [11:0] got, exp;
        int n;
        string tag;
        if (q_n.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", 1, 0);
          while (txd !== 1'b1) @(negedge clk);
        end else begin
          exp = q_bits.pop_front(); n = q_n.pop_front(); tag = q_tag.pop_front();
          got = '1;
          repeat (bit_cyc / 2) @(negedge clk);
          got[0] = txd;
          for (int i = 1; i < n; i++) begin
            repeat (bit_cyc) @(negedge clk);
            got[i] = txd;
          end
          frames_seen++;
          chk(got == exp, tag, int'(got), int'(exp));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt, fs;
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1 txd idle", int'(txd), 1);
    chk(empty === 1'b1, "R1 empty", int'(empty), 1);
    chk(irq === 1'b0, "R1 irq off", int'(irq), 0);
    chk(lb_valid === 1'b0, "R1 lb_valid", int'(lb_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq === 1'b1, "R8 irq on empty", int'(irq), 1);

    // Frame formats
    tx_en = 1'b1;
    expect_frame(8'hA5, "R2 8N1 A5");
    put(8'hA5);
    chk(irq === 1'b0, "R8 irq low while held", int'(irq), 0);
    @(negedge clk);
    chk(irq === 1'b1, "R8 irq back after load", int'(irq), 1);
    wait_idle();
    wlen = 2'b00; send(8'hF6, "R2 5-bit masked");
    wlen = 2'b01; pmode = 3'b100; send(8'h2B, "R4 6-bit odd");
    wlen = 2'b10; pmode = 3'b101; send(8'h4B, "R4 7-bit even");
    wlen = 2'b11; pmode = 3'b110; send(8'h00, "R4 mark");
    pmode = 3'b111; send(8'hFF, "R4 space");
    pmode = 3'b011; send(8'h3C, "R4 0xx no parity");
    two_stop = 1'b1; pmode = 3'b000; send(8'h81, "R3 two stop");
    chk(frames_seen == 8, "R2 frame count", frames_seen, 8);

    // R7 empty timing: 8N1 then 5-bit + parity + 2 stop
    two_stop = 1'b0;
    expect_frame(8'h55, "R7 frame 8N1");
    put(8'h55);
    cnt = 0;
    while (!empty) begin cnt++; @(negedge clk); end
    chk(cnt == 10 * bit_cyc + 1, "R7 empty 8N1", cnt, 10 * bit_cyc + 1);
    repeat (3) @(negedge clk);
    wlen = 2'b00; pmode = 3'b101; two_stop = 1'b1;
    expect_frame(8'h13, "R7 frame 5E2");
    put(8'h13);
    cnt = 0;
    while (!empty) begin cnt++; @(negedge clk); end
    chk(cnt == 9 * bit_cyc + 1, "R7 empty 5E2", cnt, 9 * bit_cyc + 1);
    repeat (3) @(negedge clk);

    // R5 bit length at a second divisor
    wlen = 2'b11; pmode = 3'b000; two_stop = 1'b0;
    div = 12'd3; bit_cyc = 64;
    expect_frame(8'h01, "R5 frame div3");
    put(8'h01);
    while (txd !== 1'b0) @(negedge clk);
    cnt = 0;
    while (txd === 1'b0) begin cnt++; @(negedge clk); end
    chk(cnt == 64, "R5 start bit length", cnt, 64);
    wait_idle();
    div = 12'd1; bit_cyc = 32;

    // R6 transmit enable gating
    tx_en = 1'b0;
    put(8'h3E);
    ok = 1'b1;
    repeat (300) begin @(negedge clk); if (txd !== 1'b1 || empty !== 1'b0) ok = 1'b0; end
    chk(ok, "R6 held while disabled", int'(ok), 1);
    expect_frame(8'h3E, "R6 sent after enable");
    tx_en = 1'b1;
    wait_idle();

    // R9 write into full holding register
    tx_en = 1'b0;
    fs = frames_seen;
    put(8'h11);
    put(8'h22);
    expect_frame(8'h11, "R9 first word kept");
    tx_en = 1'b1;
    wait_idle();
    repeat (40) @(negedge clk);
    chk(frames_seen - fs == 1, "R9 second write dropped", frames_seen - fs, 1);

    // Back-to-back writes keep order
    fs = frames_seen;
    expect_frame(8'hC3, "R2 order first");
    expect_frame(8'h5A, "R2 order second");
    put(8'hC3);
    put(8'h5A);
    wait_idle();
    chk(frames_seen - fs == 2, "R2 back-to-back count", frames_seen - fs, 2);

    // R10 break timed by one frame
    mon_on = 1'b0;
    brk = 1'b1;
    put(8'hFF);
    cnt = 0; ok = 1'b1;
    while (!empty) begin cnt++; if (txd !== 1'b0) ok = 1'b0; @(negedge clk); end
    chk(ok, "R10 line low during break", int'(ok), 1);
    chk(cnt == 10 * bit_cyc + 1, "R10 break frame time", cnt, 10 * bit_cyc + 1);
    brk = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R10 line released", int'(txd), 1);
    mon_on = 1'b1;

    // R11 loopback, 6-bit word
    fs = frames_seen;
    lpbk = 1'b1; wlen = 2'b01;
    put(8'hF3);
    chk(lb_valid === 1'b0, "R11 lb not yet", int'(lb_valid), 0);
    @(negedge clk);
    chk(lb_valid === 1'b1, "R11 lb pulse", int'(lb_valid), 1);
    chk(lb_data === 8'h33, "R11 lb data masked", int'(lb_data), 8'h33);
    chk(txd === 1'b1, "R11 line high", int'(txd), 1);
    @(negedge clk);
    chk(lb_valid === 1'b0, "R11 pulse one cycle", int'(lb_valid), 0);
    chk(empty === 1'b1, "R11 buffer emptied", int'(empty), 1);
    repeat (400) @(negedge clk);
    chk(frames_seen == fs, "R11 no serial frame", frames_seen - fs, 0);
    lpbk = 1'b0;

    repeat (10) @(negedge clk);
    chk(q_n.size() == 0, "R2 all frames seen", q_n.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule